// File: doc/BRIEF.md
# STS-1 Payload Pointer Interpreter

This block watches the byte stream of an STS-1 frame and follows where the synchronous payload envelope begins. A framer sits upstream and tags every byte with its kind: ordinary overhead, first pointer byte, second pointer byte, negative stuff opportunity (the third pointer-row overhead byte), or payload-column byte. The interpreter builds the 16-bit pointer word from the two pointer bytes. A new offset is accepted only after it has arrived three times in a row. Once an offset is held, the interpreter compares each received word against it. A majority of flipped increment bits, or a majority of flipped decrement bits, asks for a one-byte justification.

A justification is taken only when the pointer has been quiet long enough. When it is taken, the block moves the offset by one with wrap-around and pulses an event flag. It also re-qualifies the bytes around the stuff opportunity. After an increment, the first payload-column byte is marked as stuff. After a decrement, the stuff-opportunity byte itself is marked as payload. The outgoing stream carries a payload qualifier and a strobe on the first envelope byte, so later stages can extract the envelope without knowing the pointer.

The data path is a line-rate stream with one register stage. A byte enters on a cycle where `in_valid` is high and appears on the output one cycle later with `out_valid` high. There is no back-pressure: the block has no ready signal, so the source may not stall on it. Cycles with `in_valid` low are bubbles that neither advance nor disturb any state.

Top module: `sts1_ptr_interp`

## Requirements
- R1: The pointer word is {first pointer byte, second pointer byte}, numbered bit 1 (MSB of the first byte) to bit 16. The offset is the low ten bits (bits 7 to 16). The upper six bits have no effect. A received offset above OFS_LAST (782 by default) is never accepted as a new value.
- R2: After reset no offset is held, `ptr_locked` is 0 and no start strobe appears. An in-range value received identically in three consecutive frames becomes the offset. `ptr_offset` and `ptr_locked` show it from the cycle after that frame's second pointer byte.
- R3: While an offset is held, a word is an increment request when at least 3 of its I bits (pointer bits 7, 9, 11, 13, 15) differ from the held offset and none of its D bits do. A taken increment adds one to the offset, wraps OFS_LAST to 0, and pulses `inc_evt` for one cycle after the second pointer byte.
- R4: A word is a decrement request when at least 3 of the D bits (pointer bits 8, 10, 12, 14, 16) differ and no I bit does. A taken decrement subtracts one, wraps 0 to OFS_LAST, and pulses `dec_evt` for one cycle after the second pointer byte.
- R5: A word with flipped bits in both the I and the D sets is not a justification. It neither moves the offset nor raises an event flag.
- R6: A justification is taken only if at least three frames with no pointer change lie between it and the previous change (a justification or a newly accepted offset). An earlier request is ignored: no offset change, no flag, no stuff re-qualification.
- R7: In a frame with a taken increment, the first payload-column byte after the stuff-opportunity byte has `out_pay` = 0.
- R8: In a frame with a taken decrement, the stuff-opportunity byte has `out_pay` = 1. In every other frame it has `out_pay` = 0.
- R9: Payload-column bytes are numbered from 0, starting at the first one after the stuff-opportunity byte, up to OFS_LAST. `out_j1` is 1 on the byte whose number equals the held offset, but only if an offset is held and the byte is not stuff. A stuff byte keeps its number but never carries the strobe.
- R10: Every byte with `in_valid` = 1 appears unchanged on `out_data` one cycle later with `out_valid` = 1. A cycle with `in_valid` = 0 gives `out_valid` = 0. `out_pay` is 1 only on valid, numbered, non-stuff payload bytes and on a re-qualified stuff-opportunity byte.
- R11: A single frame carrying a different plain value leaves the offset unchanged. A run of identical values broken by a differing frame starts counting again from one.
- R12: Kind codes on `in_kind`: 0 overhead, 1 first pointer byte, 2 second pointer byte, 3 stuff opportunity, 4 payload column. Codes 5 to 7 act as overhead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_data | input | 8 | Input byte |
| in_kind | input | 3 | Byte kind code (R12) |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Delayed copy of the input byte |
| out_pay | output | 1 | Output byte carries envelope data |
| out_j1 | output | 1 | Output byte is the first envelope byte |
| ptr_offset | output | 10 | Held envelope offset |
| ptr_locked | output | 1 | An offset has been accepted |
| inc_evt | output | 1 | One-cycle pulse on a taken increment |
| dec_evt | output | 1 | One-cycle pulse on a taken decrement |

## Verification
The bench uses a shrunken frame of 4 rows by 8 columns, which gives 20 numbered payload bytes. With OFS_LAST = 19 it sweeps every offset through acquisition and checks the start strobe on every byte. This separates a correct position count from an off-by-one and from a strobe that leaks onto the wrong frame. Full five-bit flips are followed by three-of-five flips to show that the majority vote tolerates corrupted bits, and mixed I and D flips show that the two sets are kept apart. Requests are placed at the third and then the fourth quiet frame after a change, which pins the spacing boundary. Wraps at 0 and at the top offset, broken runs of candidate values, out-of-range values and altered upper bits test the acceptance rules.

// File: rtl/sts1_ptr_pkg.sv
package sts1_ptr_pkg;
  // Kind tag attached by the upstream framer to every byte
  typedef enum logic [2:0] {
    BK_OTHER     = 3'd0,
    BK_PTR_HI    = 3'd1,
    BK_PTR_LO    = 3'd2,
    BK_STUFF_OPP = 3'd3,
    BK_PAYLOAD   = 3'd4
  } byte_kind_e;

  localparam int PTR_WORD_W = 16;
endpackage

// File: rtl/sts1_ptr_vote.sv
module sts1_ptr_vote #(
  parameter int FLD_W = 10,
  parameter int MAJ   = 3
) (
  input  logic [FLD_W-1:0] rx_fld,
  input  logic [FLD_W-1:0] cur_fld,
  input  logic             armed,
  output logic             want_inc,
  output logic             want_dec
);
  localparam int NSET = FLD_W / 2;
  localparam int CW   = $clog2(NSET + 1);

  logic [FLD_W-1:0] flip;
  logic [NSET-1:0]  i_set;
  logic [NSET-1:0]  d_set;
  logic [CW-1:0]    i_cnt;
  logic [CW-1:0]    d_cnt;

  assign flip = rx_fld ^ cur_fld;

  // odd word bits are the increment set, even word bits the decrement set
  generate
    for (genvar g = 0; g < NSET; g++) begin : g_split
      assign i_set[g] = flip[2*g+1];
      assign d_set[g] = flip[2*g];
    end
  endgenerate

  always_comb begin
    i_cnt    = CW'($countones(i_set));
    d_cnt    = CW'($countones(d_set));
    want_inc = armed && (int'(i_cnt) >= MAJ) && (d_cnt == '0);
    want_dec = armed && (int'(d_cnt) >= MAJ) && (i_cnt == '0);
  end
endmodule

// File: rtl/sts1_ptr_track.sv
module sts1_ptr_track #(
  parameter int OFS_LAST = 782,
  parameter int FLD_W    = 10,
  parameter int ACQ_N    = 3,
  parameter int GAP_N    = 3,
  parameter int MAJ      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_stb,
  input  logic             lo_stb,
  input  logic [7:0]       byte_in,
  output logic [FLD_W-1:0] ofs_q,
  output logic             locked_q,
  output logic             inc_pls_q,
  output logic             dec_pls_q
);
  import sts1_ptr_pkg::*;

  localparam int AW = $clog2(ACQ_N + 1);
  localparam int GW = $clog2(GAP_N + 1);
  localparam logic [FLD_W-1:0] TOP = FLD_W'(OFS_LAST);

  logic [7:0]            hi_q;
  logic [PTR_WORD_W-1:0] word;
  logic [FLD_W-1:0]      rx;
  logic [FLD_W-1:0]      cand_q;
  logic [AW-1:0]         run_q;
  logic [AW-1:0]         run_nxt;
  logic [GW-1:0]         calm_q;
  logic [GW-1:0]         calm_up;
  logic                  gap_ok;
  logic                  in_rng;
  logic [FLD_W-1:0]      ofs_up;
  logic [FLD_W-1:0]      ofs_dn;
  logic                  want_inc;
  logic                  want_dec;

  assign word = {hi_q, byte_in};
  assign rx   = word[FLD_W-1:0];

  sts1_ptr_vote #(.FLD_W(FLD_W), .MAJ(MAJ)) u_vote (
    .rx_fld  (rx),
    .cur_fld (ofs_q),
    .armed   (locked_q),
    .want_inc(want_inc),
    .want_dec(want_dec)
  );

  always_comb begin
    in_rng  = (rx <= TOP);
    ofs_up  = (ofs_q == TOP) ? '0 : ofs_q + 1'b1;
    ofs_dn  = (ofs_q == '0) ? TOP : ofs_q - 1'b1;
    gap_ok  = (calm_q == GW'(GAP_N));
    calm_up = gap_ok ? calm_q : calm_q + 1'b1;
    run_nxt = (run_q != '0 && rx == cand_q) ? run_q + 1'b1 : AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      ofs_q     <= '0;
      locked_q  <= 1'b0;
      inc_pls_q <= 1'b0;
      dec_pls_q <= 1'b0;
      cand_q    <= '0;
      run_q     <= '0;
      calm_q    <= '0;
    end else begin
      inc_pls_q <= 1'b0;
      dec_pls_q <= 1'b0;
      if (hi_stb) hi_q <= byte_in;
      if (lo_stb) begin
        if (want_inc || want_dec) begin
          run_q <= '0;
          if (gap_ok) begin
            ofs_q     <= want_inc ? ofs_up : ofs_dn;
            inc_pls_q <= want_inc;
            dec_pls_q <= want_dec;
            calm_q    <= '0;
          end else begin
            calm_q <= calm_up;
          end
        end else if (in_rng && (!locked_q || rx != ofs_q)) begin
          cand_q <= rx;
          if (run_nxt == AW'(ACQ_N)) begin
            ofs_q    <= rx;
            locked_q <= 1'b1;
            run_q    <= '0;
            calm_q   <= '0;
          end else begin
            run_q  <= run_nxt;
            calm_q <= calm_up;
          end
        end else begin
          run_q  <= '0;
          calm_q <= calm_up;
        end
      end
    end
  end

  // independent spacing monitor: frames since the last event pulse
  logic [GW-1:0] mon_q;
  always_ff @(posedge clk) begin
    if (!rst_n) mon_q <= '0;
    else if (inc_pls_q || dec_pls_q) mon_q <= '0;
    else if (lo_stb && mon_q != GW'(GAP_N)) mon_q <= mon_q + 1'b1;
  end

  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |-> ofs_q <= TOP); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked_q) |-> locked_q); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pls_q |-> ofs_q == (($past(ofs_q) == TOP) ? '0 : $past(ofs_q) + 1'b1)); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec_pls_q |-> ofs_q == (($past(ofs_q) == '0) ? TOP : $past(ofs_q) - 1'b1)); // R4
  AST_EVENT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pls_q || dec_pls_q) |-> int'($past(mon_q)) >= GAP_N); // R6
endmodule

// File: rtl/sts1_spe_gate.sv
module sts1_spe_gate #(
  parameter int OFS_LAST = 782,
  parameter int FLD_W    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [7:0]               in_data,
  input  sts1_ptr_pkg::byte_kind_e in_kind,
  input  logic [FLD_W-1:0]         ofs,
  input  logic                     locked,
  input  logic                     inc_pls,
  input  logic                     dec_pls,
  output logic                     out_valid,
  output logic [7:0]               out_data,
  output logic                     out_pay,
  output logic                     out_j1
);
  import sts1_ptr_pkg::*;

  localparam int PW = $clog2(OFS_LAST + 1);
  localparam logic [PW-1:0] POS_TOP = PW'(OFS_LAST);

  logic          pend_inc_q;
  logic          pend_dec_q;
  logic          stuff_q;
  logic          run_q;
  logic [PW-1:0] pos_q;
  logic          eff_inc;
  logic          eff_dec;
  logic          pay_c;
  logic          j1_c;
  logic          at_opp;
  logic          at_pay;

  assign eff_inc = pend_inc_q | inc_pls;
  assign eff_dec = pend_dec_q | dec_pls;
  assign at_opp  = in_valid && (in_kind == BK_STUFF_OPP);
  assign at_pay  = in_valid && (in_kind == BK_PAYLOAD) && run_q;

  always_comb begin
    pay_c = 1'b0;
    j1_c  = 1'b0;
    if (at_opp) begin
      pay_c = eff_dec;
    end else if (at_pay) begin
      pay_c = !stuff_q;
      j1_c  = locked && !stuff_q && (FLD_W'(pos_q) == ofs);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_pay    <= 1'b0;
      out_j1     <= 1'b0;
      pend_inc_q <= 1'b0;
      pend_dec_q <= 1'b0;
      stuff_q    <= 1'b0;
      run_q      <= 1'b0;
      pos_q      <= '0;
    end else begin
      out_valid <= in_valid;
      out_pay   <= pay_c;
      out_j1    <= j1_c;
      if (in_valid) out_data <= in_data;

      if (at_opp) begin
        pend_inc_q <= 1'b0;
        pend_dec_q <= 1'b0;
        run_q      <= 1'b1;
        pos_q      <= '0;
        stuff_q    <= eff_inc;
      end else begin
        if (inc_pls) pend_inc_q <= 1'b1;
        if (dec_pls) pend_dec_q <= 1'b1;
        if (at_pay) begin
          stuff_q <= 1'b0;
          if (pos_q == POS_TOP) run_q <= 1'b0;
          else pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  AST_J1_IN_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_j1 |-> out_pay); // R9
  AST_PAY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_pay |-> out_valid); // R10
endmodule

// File: rtl/sts1_ptr_interp.sv
module sts1_ptr_interp #(
  parameter int OFS_LAST = 782,
  parameter int FLD_W    = 10,
  parameter int ACQ_N    = 3,
  parameter int GAP_N    = 3,
  parameter int MAJ      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic [2:0]       in_kind,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_pay,
  output logic             out_j1,
  output logic [FLD_W-1:0] ptr_offset,
  output logic             ptr_locked,
  output logic             inc_evt,
  output logic             dec_evt
);
  import sts1_ptr_pkg::*;

  byte_kind_e kind_c;
  logic       hi_stb;
  logic       lo_stb;

  // codes 5..7 fall outside the enum and act as overhead (R12)
  assign kind_c = byte_kind_e'(in_kind);
  assign hi_stb = in_valid && (kind_c == BK_PTR_HI);
  assign lo_stb = in_valid && (kind_c == BK_PTR_LO);

  sts1_ptr_track #(
    .OFS_LAST(OFS_LAST), .FLD_W(FLD_W), .ACQ_N(ACQ_N), .GAP_N(GAP_N), .MAJ(MAJ)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_stb   (hi_stb),
    .lo_stb   (lo_stb),
    .byte_in  (in_data),
    .ofs_q    (ptr_offset),
    .locked_q (ptr_locked),
    .inc_pls_q(inc_evt),
    .dec_pls_q(dec_evt)
  );

  sts1_spe_gate #(.OFS_LAST(OFS_LAST), .FLD_W(FLD_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_kind  (kind_c),
    .ofs      (ptr_offset),
    .locked   (ptr_locked),
    .inc_pls  (inc_evt),
    .dec_pls  (dec_evt),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_pay  (out_pay),
    .out_j1   (out_j1)
  );
endmodule

// File: tb/sim_sts1_ptr_interp.sv
module sim_sts1_ptr_interp;
  localparam int CLK_NS = 10;
  localparam int LAST   = 19;
  localparam int ROWS   = 4;
  localparam int COLS   = 8;
  localparam int HROW   = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] in_kind = '0;
  logic       out_valid, out_pay, out_j1, ptr_locked, inc_evt, dec_evt;
  logic [7:0] out_data;
  logic [9:0] ptr_offset;

  always #(CLK_NS/2) clk = ~clk;

  sts1_ptr_interp #(.OFS_LAST(LAST)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_kind(in_kind),
    .out_valid(out_valid), .out_data(out_data), .out_pay(out_pay), .out_j1(out_j1),
    .ptr_offset(ptr_offset), .ptr_locked(ptr_locked), .inc_evt(inc_evt), .dec_evt(dec_evt)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int r_act = 0, r_pos = 0, r_off = 0, r_lock = 0, r_stuff = 0;
  int dcnt = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int o);
    return {6'b011010, 10'(o)};
  endfunction

  // drive one byte (called at a falling edge), check the stream copy one cycle later
  task automatic put(input logic [2:0] k, input logic [7:0] d);
    in_valid = 1'b1; in_kind = k; in_data = d;
    @(negedge clk);
    chk(out_valid && out_data == d, "R10", "stream byte", int'(out_data), int'(d));
  endtask

  task automatic idle();
    in_valid = 1'b0; in_kind = 3'd0;
    @(negedge clk);
    chk(!out_valid, "R10", "bubble valid", int'(out_valid), 0);
  endtask

  // mode: 0 none, 1 increment taken, 2 decrement taken
  task automatic frame(input logic [15:0] w, input int mode, input int off, input int lock, input string req);
    idle();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (r == HROW && c == 0) begin
          put(3'd1, w[15:8]);
          chk(!out_pay && !out_j1, "R10", "ptr hi qual", int'(out_pay), 0);
        end else if (r == HROW && c == 1) begin
          put(3'd2, w[7:0]);
          chk(inc_evt == (mode == 1), (mode == 1) ? "R3" : req, "inc flag", int'(inc_evt), int'(mode == 1));
          chk(dec_evt == (mode == 2), (mode == 2) ? "R4" : req, "dec flag", int'(dec_evt), int'(mode == 2));
          chk(ptr_offset == 10'(off), req, "offset", int'(ptr_offset), off);
          chk(ptr_locked == lock[0], "R2", "locked", int'(ptr_locked), lock);
          idle();
        end else if (r == HROW && c == 2) begin
          put(3'd3, 8'(dcnt));
          chk(out_pay == (mode == 2), "R8", "stuff opp pay", int'(out_pay), int'(mode == 2));
          chk(!out_j1, "R9", "no strobe on opp", int'(out_j1), 0);
          r_act = 1; r_pos = 0; r_off = off; r_lock = lock; r_stuff = (mode == 1);
        end else if (c < 3) begin
          put((r == 0 && c == 2) ? 3'd6 : 3'd0, 8'(dcnt));
          chk(!out_pay && !out_j1, "R12", "overhead qual", int'(out_pay), 0);
        end else begin
          put(3'd4, 8'(dcnt));
          if (r_act != 0) begin
            chk(out_pay == !r_stuff, r_stuff ? "R7" : "R10", "payload qual", int'(out_pay), int'(!r_stuff));
            chk(out_j1 == (r_lock != 0 && r_pos == r_off && r_stuff == 0), "R9", "start strobe",
                int'(out_j1), int'(r_lock != 0 && r_pos == r_off && r_stuff == 0));
            r_stuff = 0;
            r_pos++;
            if (r_pos > LAST) r_act = 0;
          end else begin
            chk(!out_pay && !out_j1, "R10", "unnumbered byte", int'(out_pay), 0);
          end
        end
        dcnt++;
      end
    end
  endtask

  initial begin
    int prev;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10", "reset valid", int'(out_valid), 0);
    chk(!ptr_locked, "R2", "reset locked", int'(ptr_locked), 0);
    chk(!out_j1 && !inc_evt && !dec_evt, "R2", "reset strobes", int'(out_j1), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 acquisition
    frame(mk(5), 0, 0, 0, "R2");
    frame(mk(5), 0, 0, 0, "R2");
    frame(mk(5), 0, 5, 1, "R2");

    // R9 sweep over every offset
    prev = 5;
    for (int o = 0; o <= LAST; o++) begin
      frame(mk(o), 0, prev, 1, "R11");
      frame(mk(o), 0, prev, 1, "R11");
      frame(mk(o), 0, o, 1, "R2");
      prev = o;
    end

    // R3 increment wrap at top, stuff byte at position 0 hides the strobe
    repeat (3) frame(mk(19), 0, 19, 1, "R6");
    frame(mk(19) ^ 16'h02AA, 1, 0, 1, "R3");
    frame(mk(0), 0, 0, 1, "R6");
    frame(mk(0) ^ 16'h02AA, 0, 0, 1, "R6");   // too early, ignored
    frame(mk(0), 0, 0, 1, "R6");
    frame(mk(0), 0, 0, 1, "R6");
    // R4 three-of-five decrement, wrap at zero
    frame(mk(0) ^ 16'h0150, 2, 19, 1, "R4");
    frame(mk(19), 0, 19, 1, "R6");
    frame(mk(19), 0, 19, 1, "R6");
    frame(mk(19) ^ 16'h02AA, 0, 19, 1, "R6"); // third quiet frame: still early
    frame(mk(19) ^ 16'h02AA, 1, 0, 1, "R6");  // fourth: taken
    repeat (3) frame(mk(0), 0, 0, 1, "R6");

    // R5 mixed flips are no justification
    frame(mk(0) ^ 16'h03FF, 0, 0, 1, "R5");
    frame(mk(0) ^ 16'h02A1, 0, 0, 1, "R5");
    frame(mk(0), 0, 0, 1, "R5");
    frame(mk(0) ^ 16'h02AA, 1, 1, 1, "R3");
    repeat (3) frame(mk(1), 0, 1, 1, "R6");
    frame(mk(1) ^ 16'h0155, 2, 0, 1, "R4");
    repeat (3) frame(mk(0), 0, 0, 1, "R6");

    // R11 single glitch and broken run
    frame(mk(7), 0, 0, 1, "R11");
    frame(mk(0), 0, 0, 1, "R11");
    frame(mk(7), 0, 0, 1, "R11");
    frame(mk(7), 0, 0, 1, "R11");
    frame(mk(8), 0, 0, 1, "R11");
    frame(mk(7), 0, 0, 1, "R11");
    frame(mk(7), 0, 0, 1, "R11");
    frame(mk(7), 0, 7, 1, "R11");

    // R1 out of range never accepted, upper bits ignored
    repeat (4) frame(mk(25), 0, 7, 1, "R1");
    frame({6'b100111, 10'd12}, 0, 7, 1, "R1");
    frame({6'b000001, 10'd12}, 0, 7, 1, "R1");
    frame({6'b111111, 10'd12}, 0, 12, 1, "R1");
    repeat (3) frame(mk(12), 0, 12, 1, "R6");
    frame(mk(12) ^ 16'h02A0, 1, 13, 1, "R3");
    frame(mk(13), 0, 13, 1, "R3");

    idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule